// File: doc/BRIEF.md
# Acknowledged-Transmit Retransmission Controller

This block sequences the transmit side of an acknowledged link. When triggered with a payload waiting, it puts the radio into transmit. When the radio reports the end of the packet, the block opens a receive window and waits for an acknowledgement. If the acknowledgement comes, the payload is retired and a done flag is raised. If it does not come, the radio idles in standby until the programmed retransmit delay has run out, and then the same packet is sent again. Once the configured number of retransmissions has been used without success, a max-retry flag is raised, the payload is left in place and the controller stops.

The radio and the payload store are outside the block. The radio is modelled by strobes: end of transmission, acknowledgement seen, and reception in progress. The payload store is modelled by a non-empty level and a pop pulse. Time is counted in steps of `STEP_CYCLES` clock cycles, and one step stands for 250 µs. The receive window lasts at least one step. The retransmit delay field selects 1 to 16 steps and is measured from the end of each transmission. For long acknowledgements at slow air rates, software should program a delay of two steps or more.

Top module: `arq_tx_engine`

## Requirements
- R1: radio_mode uses the encoding 0 = standby, 1 = transmit, 2 = receive. In standby with fifo_nonempty high, a trig pulse moves the engine to transmit after one clock edge, clears retry_cnt to 0 and latches pkt_noack. A trig while fifo_nonempty is low, or while a transaction is running, has no effect.
- R2: If the latched no-ack flag is set, tx_end returns the engine to standby, sets stat_done and pulses fifo_pop once.
- R3: Otherwise tx_end puts the radio in receive, and it stays there for at least STEP_CYCLES cycles.
- R4: While rx_active is high the receive window is held open. It closes at the first edge after the minimum window at which rx_active is low.
- R5: ack_seen during the receive window sets stat_done, pulses fifo_pop once and returns the engine to standby.
- R6: Without an acknowledgement, the radio re-enters transmit exactly (cfg_retry_dly+1)*STEP_CYCLES cycles after the tx_end edge, and retry_cnt increments by one. If the window ends earlier, the radio is in standby for the remaining cycles.
- R7: ack_seen outside the receive window is ignored.
- R8: If the retry point is reached while retry_cnt equals cfg_retry_max, stat_maxrt is set, there is no pop, the engine enters standby and no further attempt is made.
- R9: A trig after max-retry resends the same packet with retry_cnt back at 0.
- R10: Driving clr_done or clr_maxrt high for one cycle clears that flag. A set in the same cycle takes precedence over the clear.
- R11: irq_n is low exactly when a flag is set whose mask input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Start-transaction pulse (chip-enable toggle) |
| pkt_noack | input | 1 | Current packet wants no acknowledgement |
| fifo_nonempty | input | 1 | A payload is waiting |
| tx_end | input | 1 | Radio finished sending the packet |
| ack_seen | input | 1 | Valid acknowledgement received |
| rx_active | input | 1 | Radio is receiving a packet |
| cfg_retry_max | input | CFG_W | Maximum retransmissions |
| cfg_retry_dly | input | CFG_W | Retransmit delay in steps minus one |
| clr_done | input | 1 | Write-one clear of the done flag |
| clr_maxrt | input | 1 | Write-one clear of the max-retry flag |
| mask_done | input | 1 | Keep the done flag off irq_n |
| mask_maxrt | input | 1 | Keep the max-retry flag off irq_n |
| radio_mode | output | 2 | Requested radio mode |
| fifo_pop | output | 1 | Retire the acknowledged payload |
| stat_done | output | 1 | Done flag |
| stat_maxrt | output | 1 | Max-retry flag |
| retry_cnt | output | CFG_W | Retransmissions of the current packet |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that the radio strobes match the requested mode: tx_end only comes during transmit, and ack_seen and rx_active only mean something during receive. They also assume that the configuration is held steady while a transaction runs, because the retry-count bound compares against a live input. The stimulus changes the configuration only in standby, pulses tx_end only after it has seen transmit mode, and raises rx_active only inside a receive window. The single exception is ack_seen, which is driven in standby on purpose to test that it is ignored.

// File: rtl/arq_pkg.sv
package arq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RXW  = 2'd2,
    ST_GAP  = 2'd3
  } arq_state_e;

  localparam logic [1:0] MODE_STBY = 2'd0;
  localparam logic [1:0] MODE_TX   = 2'd1;
  localparam logic [1:0] MODE_RX   = 2'd2;
endpackage

// File: rtl/arq_gap_timer.sv
module arq_gap_timer #(
  parameter int STEP_CYCLES = 2500,
  parameter int CFG_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [CFG_W-1:0] cfg_dly,
  output logic             win_end,
  output logic             gap_end
);
  localparam int TOT_MAX = (1 << CFG_W) * STEP_CYCLES;
  localparam int CW      = $clog2(TOT_MAX + 1);

  logic [CW-1:0] elapsed;
  logic [CW-1:0] tot_m1;

  // free-running elapsed-cycle counter, saturating, restarted at each tx end
  always_ff @(posedge clk) begin
    if (rst || clr) elapsed <= '0;
    else if (elapsed != '1) elapsed <= elapsed + CW'(1);
  end

  always_comb begin
    tot_m1  = (CW'(cfg_dly) + CW'(1)) * CW'(STEP_CYCLES) - CW'(1);
    win_end = (elapsed >= CW'(STEP_CYCLES - 1));
    gap_end = (elapsed >= tot_m1);
  end
endmodule

// File: rtl/arq_irq_flags.sv
module arq_irq_flags #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set,
  input  logic [NSRC-1:0] clr,
  input  logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] flag,
  output logic            irq_n
);
  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_src
      always_ff @(posedge clk) begin
        if (rst)         flag[i] <= 1'b0;
        else if (set[i]) flag[i] <= 1'b1;
        else if (clr[i]) flag[i] <= 1'b0;
      end

      a_r10_clear_wins_alone: assert property (@(posedge clk) disable iff (rst)
        (clr[i] && !set[i]) |=> !flag[i]);
      a_r10_set_sticks: assert property (@(posedge clk) disable iff (rst)
        set[i] |=> flag[i]);
    end
  endgenerate

  assign irq_n = ~|(flag & ~mask);
endmodule

// File: rtl/arq_tx_engine.sv
module arq_tx_engine
  import arq_pkg::*;
#(
  parameter int STEP_CYCLES = 2500,
  parameter int CFG_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic             pkt_noack,
  input  logic             fifo_nonempty,
  input  logic             tx_end,
  input  logic             ack_seen,
  input  logic             rx_active,
  input  logic [CFG_W-1:0] cfg_retry_max,
  input  logic [CFG_W-1:0] cfg_retry_dly,
  input  logic             clr_done,
  input  logic             clr_maxrt,
  input  logic             mask_done,
  input  logic             mask_maxrt,
  output logic [1:0]       radio_mode,
  output logic             fifo_pop,
  output logic             stat_done,
  output logic             stat_maxrt,
  output logic [CFG_W-1:0] retry_cnt,
  output logic             irq_n
);
  arq_state_e st;
  logic noack_q;
  logic win_end, gap_end;
  logic tx_fin, ack_ok, done_ev, win_close, retry_pt, fail_ev;
  logic [1:0] flags;

  always_comb begin
    tx_fin    = (st == ST_TX) && tx_end;
    ack_ok    = (st == ST_RXW) && ack_seen;
    done_ev   = (tx_fin && noack_q) || ack_ok;
    win_close = (st == ST_RXW) && !ack_seen && win_end && !rx_active;
    retry_pt  = (win_close && gap_end) || ((st == ST_GAP) && gap_end);
    fail_ev   = retry_pt && (retry_cnt == cfg_retry_max);
  end

  arq_gap_timer #(.STEP_CYCLES(STEP_CYCLES), .CFG_W(CFG_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (tx_fin),
    .cfg_dly (cfg_retry_dly),
    .win_end (win_end),
    .gap_end (gap_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      noack_q   <= 1'b0;
      retry_cnt <= '0;
      fifo_pop  <= 1'b0;
    end else begin
      fifo_pop <= done_ev;
      unique case (st)
        ST_IDLE: if (trig && fifo_nonempty) begin
          st        <= ST_TX;
          retry_cnt <= '0;
          noack_q   <= pkt_noack;
        end
        ST_TX: if (tx_end) st <= noack_q ? ST_IDLE : ST_RXW;
        ST_RXW: begin
          if (ack_seen) st <= ST_IDLE;
          else if (win_close) begin
            if (!gap_end) st <= ST_GAP;
            else if (fail_ev) st <= ST_IDLE;
            else begin
              st        <= ST_TX;
              retry_cnt <= retry_cnt + CFG_W'(1);
            end
          end
        end
        ST_GAP: if (gap_end) begin
          if (fail_ev) st <= ST_IDLE;
          else begin
            st        <= ST_TX;
            retry_cnt <= retry_cnt + CFG_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      ST_TX:   radio_mode = MODE_TX;
      ST_RXW:  radio_mode = MODE_RX;
      default: radio_mode = MODE_STBY;
    endcase
  end

  arq_irq_flags #(.NSRC(2)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set   ({fail_ev, done_ev}),
    .clr   ({clr_maxrt, clr_done}),
    .mask  ({mask_maxrt, mask_done}),
    .flag  (flags),
    .irq_n (irq_n)
  );
  assign stat_done  = flags[0];
  assign stat_maxrt = flags[1];

  a_r3_rx_follows_tx: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TX && tx_end && !noack_q) |=> (radio_mode == MODE_RX));
  a_r4_window_held: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RXW && rx_active && !ack_seen) |=> (radio_mode == MODE_RX));
  a_r5_single_pop: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> !fifo_pop);
  a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |-> (retry_cnt <= cfg_retry_max));
  a_r8_payload_kept: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_maxrt) |-> (!fifo_pop && radio_mode == MODE_STBY));
  a_r7_gap_is_standby: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GAP && ack_seen && !gap_end) |=> (radio_mode == MODE_STBY));
endmodule

// File: tb/tb_arq_tx_engine.sv
module tb_arq_tx_engine;
  localparam int STEP = 4;
  localparam int CW   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 0, pkt_noack = 0, fifo_nonempty = 1, tx_end = 0, ack_seen = 0, rx_active = 0;
  logic [CW-1:0] cfg_retry_max = 0, cfg_retry_dly = 0;
  logic clr_done = 0, clr_maxrt = 0, mask_done = 0, mask_maxrt = 0;
  logic [1:0] radio_mode;
  logic fifo_pop, stat_done, stat_maxrt, irq_n;
  logic [CW-1:0] retry_cnt;

  int checks = 0, errors = 0, pops = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  arq_tx_engine #(.STEP_CYCLES(STEP), .CFG_W(CW)) dut (
    .clk(clk), .rst(rst), .trig(trig), .pkt_noack(pkt_noack),
    .fifo_nonempty(fifo_nonempty), .tx_end(tx_end), .ack_seen(ack_seen),
    .rx_active(rx_active), .cfg_retry_max(cfg_retry_max), .cfg_retry_dly(cfg_retry_dly),
    .clr_done(clr_done), .clr_maxrt(clr_maxrt), .mask_done(mask_done),
    .mask_maxrt(mask_maxrt), .radio_mode(radio_mode), .fifo_pop(fifo_pop),
    .stat_done(stat_done), .stat_maxrt(stat_maxrt), .retry_cnt(retry_cnt), .irq_n(irq_n)
  );

  always @(negedge clk) if (!rst && fifo_pop) pops++;

  // {dly[15:12], max[11:8], noack[7], 3'b0, ack_at[3:0]}; ack_at 15 = never
  localparam logic [15:0] VEC [6] = '{16'h038F, 16'h0300, 16'h2302, 16'h120F, 16'h000F, 16'h3101};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic clear_flags();
    clr_done = 1; clr_maxrt = 1; tick(); clr_done = 0; clr_maxrt = 0;
  endtask

  task automatic start_txn();
    trig = 1; tick(); trig = 0;
  endtask

  task automatic end_tx();
    tx_end = 1; tick(); tx_end = 0;
  endtask

  task automatic run_vec(input logic [15:0] v);
    int d, mx, ackat, attempts, p0, exp_att;
    bit noack, fin, ok;
    d = int'(v[15:12]); mx = int'(v[11:8]); noack = v[7]; ackat = int'(v[3:0]);
    cfg_retry_dly = v[15:12]; cfg_retry_max = v[11:8]; pkt_noack = noack;
    clear_flags();
    p0 = pops; attempts = 0; fin = 0;
    start_txn();
    chk("R1 start mode", int'(radio_mode), 1);
    chk("R1 retry_cnt cleared", int'(retry_cnt), 0);
    while (!fin && attempts < 20) begin
      end_tx();
      attempts++;
      if (noack) begin
        chk("R2 noack standby", int'(radio_mode), 0);
        fin = 1;
      end else begin
        chk("R3 receive after tx", int'(radio_mode), 2);
        if (attempts - 1 == ackat) begin
          ack_seen = 1; tick(); ack_seen = 0;
          chk("R5 ack standby", int'(radio_mode), 0);
          fin = 1;
        end else begin
          int j;
          j = 0;
          while (radio_mode == 2'd2 && j < 300) begin tick(); j++; end
          chk("R3 window length", j, STEP);
          while (radio_mode != 2'd1 && !stat_maxrt && j < 300) begin tick(); j++; end
          chk("R6 retransmit spacing", j, (d + 1) * STEP);
          if (stat_maxrt) begin
            chk("R8 maxrt standby", int'(radio_mode), 0);
            fin = 1;
          end else chk("R6 retry_cnt step", int'(retry_cnt), attempts);
        end
      end
    end
    ok = noack || (ackat <= mx);
    exp_att = noack ? 1 : (ok ? ackat + 1 : mx + 1);
    tick(); tick();
    chk("R8 attempt count", attempts, exp_att);
    chk("R2 R5 done flag", int'(stat_done), int'(ok));
    chk("R8 maxrt flag", int'(stat_maxrt), int'(!ok));
    chk("R5 R8 pop count", pops - p0, ok ? 1 : 0);
    chk("R6 final retry_cnt", int'(retry_cnt), exp_att - 1);
    chk("R8 no further attempt", int'(radio_mode), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0; tick();
    chk("R1 reset mode", int'(radio_mode), 0);
    chk("R11 reset irq_n", int'(irq_n), 1);
    chk("R10 reset flags", int'({stat_done, stat_maxrt}), 0);
    chk("R1 reset retry_cnt", int'(retry_cnt), 0);

    for (int k = 0; k < 6; k++) run_vec(VEC[k]);

    // R1: trigger with empty store is ignored
    clear_flags();
    fifo_nonempty = 0; start_txn(); tick();
    chk("R1 empty ignored", int'(radio_mode), 0);
    fifo_nonempty = 1;

    // R4: window stretched by reception in progress, then straight to transmit
    cfg_retry_dly = 0; cfg_retry_max = 1; pkt_noack = 0;
    start_txn(); end_tx();
    rx_active = 1;
    repeat (STEP + 3) tick();
    chk("R4 window held", int'(radio_mode), 2);
    rx_active = 0; tick();
    chk("R4 close to transmit", int'(radio_mode), 1);
    chk("R4 retry_cnt", int'(retry_cnt), 1);
    // R1: trig while busy ignored
    start_txn();
    chk("R1 busy trig ignored", int'(retry_cnt), 1);
    end_tx(); ack_seen = 1; tick(); ack_seen = 0;
    chk("R5 ack after stretch", int'(stat_done), 1);
    clear_flags();

    // R7: acknowledgement in the standby gap has no effect
    cfg_retry_dly = 3; cfg_retry_max = 1;
    start_txn(); end_tx();
    repeat (STEP + 1) tick();
    chk("R6 gap standby", int'(radio_mode), 0);
    ack_seen = 1; tick(); ack_seen = 0;
    chk("R7 ack ignored flag", int'(stat_done), 0);
    chk("R7 ack ignored mode", int'(radio_mode), 0);
    while (radio_mode != 2'd1) tick();
    chk("R7 retransmit still occurs", int'(retry_cnt), 1);
    end_tx(); ack_seen = 1; tick(); ack_seen = 0; tick();
    clear_flags();

    // R9: restart after max-retry
    cfg_retry_dly = 0; cfg_retry_max = 0;
    begin
      int p0;
      p0 = pops;
      start_txn(); end_tx();
      repeat (STEP + 1) tick();
      chk("R8 maxrt set", int'(stat_maxrt), 1);
      chk("R11 irq low on maxrt", int'(irq_n), 0);
      mask_maxrt = 1; tick();
      chk("R11 masked maxrt", int'(irq_n), 1);
      mask_maxrt = 0;
      start_txn();
      chk("R9 restart mode", int'(radio_mode), 1);
      chk("R9 restart retry_cnt", int'(retry_cnt), 0);
      end_tx(); ack_seen = 1; tick(); ack_seen = 0; tick();
      chk("R9 one pop total", pops - p0, 1);
    end
    clr_maxrt = 1; tick(); clr_maxrt = 0;
    chk("R10 maxrt cleared", int'(stat_maxrt), 0);
    chk("R10 done kept", int'(stat_done), 1);
    mask_done = 1; tick();
    chk("R11 masked done", int'(irq_n), 1);
    mask_done = 0; tick();
    chk("R11 unmasked done", int'(irq_n), 0);
    clear_flags();

    // R10: set beats simultaneous clear
    pkt_noack = 1;
    start_txn();
    clr_done = 1; tx_end = 1; tick(); tx_end = 0; clr_done = 0;
    chk("R10 set wins", int'(stat_done), 1);
    clr_done = 1; tick(); clr_done = 0;
    chk("R10 write-one clear", int'(stat_done), 0);
    chk("R11 irq released", int'(irq_n), 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule